// File: doc/BRIEF.md
# Tree Reduction Sum Controller

This block totals a set of partial sums, one held by each of `NUM_PE` processing elements, by modelling a message-passing reduction tree in hardware. A single start strobe captures every partial sum in parallel from a flat input vector. The block then runs one reduction round per clock. In each round the elements in the upper part of the active range pass their value to a partner lower down, and that partner adds the value to its own. The rounds go on until only element zero still holds a live value, and that value is the total.

The element count does not have to be a power of two. Each round computes a new split point `half = (half + 1) / 2`, with integer division. Elements whose index lies in `[half, limit)` send to `index - half`. Elements whose index is below `limit / 2` receive and add. After the round, `limit` takes the value of `half`. When the active count is odd, the middle element neither sends nor receives in that round, and it becomes the upper limit for the next round. The run ends in the round where `half` reaches 1. Message transfer is modelled as a register move that takes one cycle.

A done flag then rises and stays high, with the total held steady, until the next start. The block ignores a start strobe that arrives while a reduction is still running.

Top module: `tree_reduce_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o` is 0 and `total_o` is 0.
- R2: On completion, `total_o` equals the sum of all `NUM_PE` lanes captured at start. Lane k occupies bits [32k+31:32k] of `partial_i`.
- R3: Each round sets half to (half+1)/2 and adds the value of element i+half into element i for every i below limit/2. Elements at or above limit, and the odd middle element at index limit/2 when limit is odd, keep their value.
- R4: Each round takes one clock. `done_o` rises exactly R rising edges after the edge that samples `start_i`. R is the number of halvings that bring `NUM_PE` down to 1, taking at least one; it is 7 for 100 elements.
- R5: Once `done_o` is high, it and `total_o` stay unchanged until a new start is sampled.
- R6: A `start_i` pulse sampled while rounds are in progress has no effect: the run keeps its original data and timing.
- R7: Additions are 32-bit two's complement and wrap modulo 2^32 with no flag.
- R8: A start sampled while `done_o` is high clears `done_o` at that same edge and begins a new reduction on the newly presented lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; captures `partial_i` when idle or done |
| partial_i | input | NUM_PE*32 | Partial sums, lane k at bits [32k+31:32k] |
| done_o | output | 1 | High from completion until the next accepted start |
| total_o | output | 32 | Value of element 0; the total while `done_o` is high |

## Verification
The two functions that can meet in one cycle are a round update and a start strobe. The bench provokes this by pulsing start with a different lane vector in the middle of the run, and also while the block sits in the done state. In the first case the bench expects the original total and the original round count, since the strobe must have no effect. In the second case it expects `done_o` to drop at once and the new vector's total to follow after the full round count.

// File: rtl/tr_pkg.sv
package tr_pkg;

    localparam int SUM_W = 32;
    localparam int CNT_W = 8;

    typedef logic [SUM_W-1:0] sum_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tr_state_e;

    // Active window of one reduction round.
    typedef struct packed {
        cnt_t limit;   // exclusive upper bound of live elements
        cnt_t half;    // split point: senders sit at [half, limit)
    } tr_span_t;

    // Split point rounded up so an odd middle element sits out.
    function automatic cnt_t halve_up(input cnt_t h);
        logic [CNT_W:0] wide;
        wide = {1'b0, h} + {{CNT_W{1'b0}}, 1'b1};
        return wide[CNT_W:1];
    endfunction

endpackage

// File: rtl/tr_sequencer.sv
module tr_sequencer
    import tr_pkg::*;
#(
    parameter int NUM_PE = 100
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    output logic     load_o,
    output logic     round_en_o,
    output tr_span_t rspan_o,
    output logic     done_o
);

    localparam cnt_t PE_CNT = cnt_t'(NUM_PE);

    tr_state_e state_q;
    tr_span_t  span_q;
    cnt_t      nxt_half;

    assign nxt_half = halve_up(span_q.half);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            span_q  <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    span_q.limit <= nxt_half;
                    span_q.half  <= nxt_half;
                    if (nxt_half == cnt_t'(1))
                        state_q <= ST_DONE;
                end
                default: begin
                    if (start_i) begin
                        state_q      <= ST_RUN;
                        span_q.limit <= PE_CNT;
                        span_q.half  <= PE_CNT;
                    end
                end
            endcase
        end
    end

    assign load_o        = start_i && (state_q != ST_RUN);
    assign round_en_o    = (state_q == ST_RUN);
    assign rspan_o.limit = span_q.limit;
    assign rspan_o.half  = nxt_half;
    assign done_o        = (state_q == ST_DONE);

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o); // R5

    AST_RUN_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        round_en_o |=> (done_o || (span_q.half < $past(span_q.half)))); // R6

    AST_DONE_AT_UNIT_HALF: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (span_q.half == cnt_t'(1))); // R4

    AST_DONE_AFTER_ROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(round_en_o)); // R4

endmodule

// File: rtl/tr_pe_array.sv
module tr_pe_array
    import tr_pkg::*;
#(
    parameter int NUM_PE = 100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic [NUM_PE*SUM_W-1:0] partial_i,
    input  logic                    round_en_i,
    input  tr_span_t                span_i,
    output sum_t                    total_o
);

    localparam int PIDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1;

    sum_t sum_q [NUM_PE];
    cnt_t recv_lim;

    assign recv_lim = span_i.limit >> 1;

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        localparam cnt_t MY_IDX = cnt_t'(g);

        logic              takes_in;
        logic [PIDX_W-1:0] partner;
        sum_t              incoming;

        assign takes_in = round_en_i && (MY_IDX < recv_lim);
        assign partner  = PIDX_W'(MY_IDX + span_i.half);
        assign incoming = sum_q[partner];

        always_ff @(posedge clk) begin
            if (rst)
                sum_q[g] <= '0;
            else if (load_i)
                sum_q[g] <= partial_i[g*SUM_W +: SUM_W];
            else if (takes_in)
                sum_q[g] <= sum_q[g] + incoming;
        end

        AST_OUTSIDE_STEADY: assert property (@(posedge clk) disable iff (rst)
            (round_en_i && (MY_IDX >= span_i.limit)) |=> $stable(sum_q[g])); // R3

        AST_ODD_MIDDLE_STEADY: assert property (@(posedge clk) disable iff (rst)
            (round_en_i && span_i.limit[0] && (MY_IDX == recv_lim))
            |=> $stable(sum_q[g])); // R3
    end

    assign total_o = sum_q[0];

endmodule

// File: rtl/tree_reduce_ctrl.sv
module tree_reduce_ctrl
    import tr_pkg::*;
#(
    parameter int NUM_PE = 100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [NUM_PE*SUM_W-1:0] partial_i,
    output logic                    done_o,
    output logic [SUM_W-1:0]        total_o
);

    logic     load;
    logic     round_en;
    tr_span_t rspan;

    tr_sequencer #(.NUM_PE(NUM_PE)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .load_o     (load),
        .round_en_o (round_en),
        .rspan_o    (rspan),
        .done_o     (done_o)
    );

    tr_pe_array #(.NUM_PE(NUM_PE)) u_pes (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .partial_i  (partial_i),
        .round_en_i (round_en),
        .span_i     (rspan),
        .total_o    (total_o)
    );

    AST_TOTAL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> $stable(total_o)); // R5

    AST_NO_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        round_en |-> !load); // R6

endmodule

// File: tb/tree_reduce_ctrl_tb_top.sv
`timescale 1ns/1ps
module tree_reduce_ctrl_tb_top;

    localparam int N = 100;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [N*W-1:0] partial_i = '0;
    logic           done_o;
    logic [W-1:0]   total_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tree_reduce_ctrl #(.NUM_PE(N)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .partial_i(partial_i), .done_o(done_o), .total_o(total_o)
    );

    function automatic logic [W-1:0] exp_total(input logic [N*W-1:0] v);
        logic [W-1:0] s = '0;
        for (int k = 0; k < N; k++) s = s + v[k*W +: W];
        return s;
    endfunction

    function automatic int exp_rounds(input int n);
        int h = n;
        int r = 0;
        do begin
            h = (h + 1) / 2;
            r++;
        end while (h != 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [N*W-1:0] v);
        @(negedge clk);
        partial_i = v;
        start_i   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i   = 1'b0;
    endtask

    // Run one reduction; optionally inject a second start mid-run.
    task automatic run_case(input logic [N*W-1:0] v, input bit inject,
                            input logic [N*W-1:0] v2);
        int cyc = 0;
        logic [W-1:0] hold;
        pulse_start(v);
        check(done_o == 1'b0, "R8 done low after start", W'(done_o), 0);
        cyc = 1;
        while (!done_o && cyc < 60) begin
            if (inject && cyc == 3) begin
                partial_i = v2;
                start_i   = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (!done_o) cyc++;
        end
        check(cyc == exp_rounds(N), "R4 round count", W'(cyc), W'(exp_rounds(N)));
        check(total_o == exp_total(v),
              inject ? "R6 total after ignored start" : "R2 R7 total",
              total_o, exp_total(v));
        hold = total_o;
        repeat (3) @(negedge clk);
        check(done_o == 1'b1 && total_o == hold, "R5 done and total held",
              total_o, hold);
    endtask

    initial begin
        logic [N*W-1:0] v;
        logic [N*W-1:0] v2;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 done at reset", W'(done_o), 0);
        check(total_o == '0, "R1 total at reset", total_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && total_o == '0, "R1 after reset", total_o, 0);

        run_case('0, 0, '0);
        v = '0;
        for (int k = 0; k < N; k++) v[k*W +: W] = 32'hFFFF_FFFF;
        run_case(v, 0, '0);                      // R7: sum of -1s
        for (int k = 0; k < N; k++) v[k*W +: W] = 32'h7FFF_FFFF;
        run_case(v, 0, '0);                      // R7 overflow wrap
        v = '0; v[(N-1)*W +: W] = 32'd77;
        run_case(v, 0, '0);                      // R3 last element routing
        v = '0; v[12*W +: W] = 32'd5; v[24*W +: W] = 32'd9; v[49*W +: W] = 32'd3;
        run_case(v, 0, '0);                      // R3 odd middle lanes
        for (int t = 0; t < 10; t++) begin
            for (int k = 0; k < N; k++) v[k*W +: W] = $urandom();
            run_case(v, 0, '0);                  // R2 random
        end
        for (int k = 0; k < N; k++) begin
            v[k*W +: W]  = $urandom();
            v2[k*W +: W] = $urandom();
        end
        run_case(v, 1, v2);                      // R6 start mid-run
        run_case(v2, 0, '0);                     // R8 restart from done
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule